// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block sits between a register bank's write port and the bank itself. It decides, for every write, whether the addressed register may take the data. The decision is made with a per-register write-enable vector. A parameter mask names the protected registers. Writes to a protected register are only let through while the guard is open. Writes to unprotected registers always pass.

The guard opens only after two key words are written, in order, to two kick registers. Both keys must be full 32-bit writes. Any other write to either kick register closes the guard again, and a zero write is the normal way to close it. The kick registers live inside the guard and never reach the bank. Reads are outside the block's path, so they are never blocked.

Top module: `reg_key_guard`

## Requirements
- R1: After reset the guard is closed: `unlocked` is 0, and no protected register gets a write enable.
- R2: The guard opens when the first kick register (word index 27, byte offset 0x6C) takes a full-word write of 0x83E70B13, and then the second kick register (word index 28, offset 0x70) takes a full-word write of 0x95A4F1E0. `unlocked` reads 1 in the cycle after the second write.
- R3: A correct second key written while the guard is closed and not armed by a correct first key leaves the guard closed.
- R4: Any full-word write of a value other than its key, including zero, to either kick register closes the guard from the next cycle. This holds in every state, including the armed state.
- R5: A byte-wide write (`wr_word`=0) to a kick register closes the guard, whatever its data.
- R6: While the guard is closed, a write to a protected register raises no write enable, so the register keeps its contents.
- R7: A write to an unprotected register raises its write enable in the same cycle, whatever the guard state.
- R8: Each write raises at most one enable bit, at index `wr_addr[ADDR_W-1:2]`. No enable bit is raised without `wr_valid`, for either kick register, or for an index of `REG_COUNT` or more.
- R9: Writes to other registers between the two keys do not cancel the armed state. A correct first key written while open keeps the guard open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_word | input | 1 | 1 = full 32-bit write, 0 = byte write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| reg_we | output | REG_COUNT | One-hot write enable to the register bank |
| unlocked | output | 1 | Guard is open |

## Verification
The hardest state to reach is the armed state: the first key has been accepted, but the second has not yet been written. That is the only state where a wrong second-kick value, a byte write, or an unrelated register write makes a visible difference. The stimulus therefore writes the first key and then, before the second key, tries each disturbance in turn. It then shows the effect at the ports by sending the second key and a protected write. Whether that write is enabled tells whether the arm survived.

// File: rtl/reg_key_guard_pkg.sv
package reg_key_guard_pkg;
   typedef enum logic [1:0] {
      GUARD_SHUT  = 2'd0,
      GUARD_ARMED = 2'd1,
      GUARD_OPEN  = 2'd2
   } guard_state_e;

   localparam int unsigned KEY_W = 32;
endpackage

// File: rtl/reg_key_guard_fsm.sv
module reg_key_guard_fsm
   import reg_key_guard_pkg::*;
#(
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned KICK_A   = 27,
   parameter int unsigned KICK_B   = 28,
   parameter logic [KEY_W-1:0] KEY_A = 32'h83E7_0B13,
   parameter logic [KEY_W-1:0] KEY_B = 32'h95A4_F1E0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             wr_word,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_data,
   output logic             open_o
);
   guard_state_e state_q, state_d;
   logic hit_a, hit_b, good_a, good_b;

   assign hit_a  = wr_valid && (wr_idx == IDX_W'(KICK_A));
   assign hit_b  = wr_valid && (wr_idx == IDX_W'(KICK_B));
   assign good_a = wr_word && (wr_data == KEY_A);
   assign good_b = wr_word && (wr_data == KEY_B);

   always_comb begin
      state_d = state_q;
      if (hit_a) begin
         if (!good_a)                   state_d = GUARD_SHUT;
         else if (state_q != GUARD_OPEN) state_d = GUARD_ARMED;
      end else if (hit_b) begin
         if (good_b && state_q != GUARD_SHUT) state_d = GUARD_OPEN;
         else                                 state_d = GUARD_SHUT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GUARD_SHUT;
      else        state_q <= state_d;
   end

   assign open_o = (state_q == GUARD_OPEN);
endmodule

// File: rtl/reg_key_guard_dec.sv
module reg_key_guard_dec #(
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned REG_COUNT = 40,
   parameter int unsigned KICK_A    = 27,
   parameter int unsigned KICK_B    = 28,
   parameter logic [REG_COUNT-1:0] PROT_MASK = '0
) (
   input  logic                 wr_valid,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic                 open_i,
   output logic [REG_COUNT-1:0] we_o
);
   for (genvar i = 0; i < REG_COUNT; i++) begin : g_slot
      if (i == KICK_A || i == KICK_B) begin : g_kick
         assign we_o[i] = 1'b0;
      end else if (PROT_MASK[i]) begin : g_prot
         assign we_o[i] = wr_valid && (wr_idx == IDX_W'(i)) && open_i;
      end else begin : g_free
         assign we_o[i] = wr_valid && (wr_idx == IDX_W'(i));
      end
   end
endmodule

// File: rtl/reg_key_guard.sv
module reg_key_guard
   import reg_key_guard_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned REG_COUNT = 40,
   parameter logic [REG_COUNT-1:0] PROT_MASK = 40'h3F_0007_FFFF,
   parameter int unsigned KICK_A_OFF = 'h6C,
   parameter int unsigned KICK_B_OFF = 'h70,
   parameter logic [KEY_W-1:0] KEY_A = 32'h83E7_0B13,
   parameter logic [KEY_W-1:0] KEY_B = 32'h95A4_F1E0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic                 wr_word,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [KEY_W-1:0]     wr_data,
   output logic [REG_COUNT-1:0] reg_we,
   output logic                 unlocked
);
   localparam int unsigned IDX_W  = ADDR_W - 2;
   localparam int unsigned KICK_A = KICK_A_OFF / 4;
   localparam int unsigned KICK_B = KICK_B_OFF / 4;

   if (REG_COUNT > (1 << IDX_W)) begin : g_bad_count
      $error("REG_COUNT exceeds the address space");
   end
   if ((KICK_A_OFF % 4) != 0 || (KICK_B_OFF % 4) != 0) begin : g_bad_align
      $error("kick offsets must be word aligned");
   end
   if (KICK_A == KICK_B) begin : g_bad_kick
      $error("kick registers must differ");
   end

   logic [IDX_W-1:0] idx;
   logic             open_w;

   assign idx = wr_addr[ADDR_W-1:2];

   reg_key_guard_fsm #(
      .IDX_W(IDX_W), .KICK_A(KICK_A), .KICK_B(KICK_B),
      .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) fsm_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
      .wr_idx(idx), .wr_data(wr_data), .open_o(open_w)
   );

   reg_key_guard_dec #(
      .IDX_W(IDX_W), .REG_COUNT(REG_COUNT), .KICK_A(KICK_A),
      .KICK_B(KICK_B), .PROT_MASK(PROT_MASK)
   ) dec_i (
      .wr_valid(wr_valid), .wr_idx(idx), .open_i(open_w), .we_o(reg_we)
   );

   assign unlocked = open_w;
endmodule

// File: rtl/reg_key_guard_chk.sv
module reg_key_guard_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned REG_COUNT = 40,
   parameter logic [REG_COUNT-1:0] PROT_MASK = '0,
   parameter int unsigned KICK_A_OFF = 'h6C,
   parameter int unsigned KICK_B_OFF = 'h70,
   parameter logic [31:0] KEY_A = '0,
   parameter logic [31:0] KEY_B = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_valid,
   input logic                 wr_word,
   input logic [ADDR_W-1:0]    wr_addr,
   input logic [31:0]          wr_data,
   input logic [REG_COUNT-1:0] reg_we,
   input logic                 unlocked
);
   logic kick_a, kick_b;
   assign kick_a = wr_valid && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(KICK_A_OFF / 4));
   assign kick_b = wr_valid && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(KICK_B_OFF / 4));

   // R1
   reset_shut_chk: assert property (@(posedge clk) !rst_n |=> !unlocked);

   // R6
   locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> ((reg_we & PROT_MASK) == '0));

   // R2
   open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(kick_b && wr_word && wr_data == KEY_B));

   // R4
   bad_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((kick_a && wr_word && wr_data != KEY_A) || (kick_b && wr_word && wr_data != KEY_B))
      |=> !unlocked);

   // R5
   byte_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((kick_a || kick_b) && !wr_word) |=> !unlocked);

   // R8
   one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_we) && (wr_valid || reg_we == '0) && (!(kick_a || kick_b) || reg_we == '0));
endmodule

bind reg_key_guard reg_key_guard_chk #(
   .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT), .PROT_MASK(PROT_MASK),
   .KICK_A_OFF(KICK_A_OFF), .KICK_B_OFF(KICK_B_OFF), .KEY_A(KEY_A), .KEY_B(KEY_B)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
   .wr_addr(wr_addr), .wr_data(wr_data), .reg_we(reg_we), .unlocked(unlocked)
);

// File: tb/reg_key_guard_tb_top.sv
module reg_key_guard_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int NREG = 40;
   localparam logic [NREG-1:0] MASK = 40'h3F_0007_FFFF;
   localparam logic [31:0] K0 = 32'h83E7_0B13;
   localparam logic [31:0] K1 = 32'h95A4_F1E0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0, wr_word = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [NREG-1:0] reg_we;
   logic unlocked;

   int checks = 0, errors = 0;
   int mstate = 0; // 0 shut, 1 armed, 2 open
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reg_key_guard dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
      .wr_addr(wr_addr), .wr_data(wr_data), .reg_we(reg_we), .unlocked(unlocked)
   );

   function automatic logic [NREG-1:0] exp_we(bit v, int a);
      int idx = a / 4;
      if (!v || idx >= NREG || idx == 27 || idx == 28) return '0;
      if (MASK[idx] && mstate != 2) return '0;
      return NREG'(1) << idx;
   endfunction

   task automatic step(string req, bit v, bit w, int a, logic [31:0] d);
      logic [NREG-1:0] e;
      @(negedge clk);
      wr_valid = v; wr_word = w; wr_addr = AW'(a); wr_data = d;
      #1;
      e = exp_we(v, a);
      checks++;
      if (reg_we !== e || unlocked !== (mstate == 2)) begin
         errors++;
         $display("FAIL %s: we=%h unlocked=%b expected we=%h unlocked=%b",
                  req, reg_we, unlocked, e, mstate == 2);
      end
      if (v && a / 4 == 27)
         mstate = (w && d == K0) ? ((mstate == 2) ? 2 : 1) : 0;
      else if (v && a / 4 == 28)
         mstate = (w && d == K1 && mstate != 0) ? 2 : 0;
   endtask

   task automatic unlock_seq(string req);
      step(req, 1, 1, 'h6C, K0);
      step(req, 1, 1, 'h70, K1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1 reset state, protected write dropped
      step("R1", 0, 0, 0, 0);
      step("R1", 1, 1, 'h08, 32'h12);
      // R6 every protected register blocked while shut
      for (int i = 0; i < 19; i++) step("R6", 1, 1, i * 4, 32'h5A);
      // R7 unprotected registers always pass
      step("R7", 1, 1, 'h54, 32'h1);
      step("R7", 1, 0, 'h7C, 32'h2);
      // R3 second key alone
      step("R3", 1, 1, 'h70, K1);
      step("R3", 1, 1, 'h40, 32'h3);
      // R2 proper sequence
      unlock_seq("R2");
      step("R2", 1, 1, 'h40, 32'h3);
      step("R2", 1, 0, 'h84, 32'h4);
      // R9 rekey first while open keeps open
      step("R9", 1, 1, 'h6C, K0);
      step("R9", 1, 1, 'h00, 32'h5);
      // R4 zero relock
      step("R4", 1, 1, 'h6C, 0);
      step("R4", 1, 1, 'h00, 32'h6);
      unlock_seq("R4");
      step("R4", 1, 1, 'h70, 0);
      step("R4", 1, 1, 'h14, 32'h7);
      // R4 wrong second key from armed
      step("R4", 1, 1, 'h6C, K0);
      step("R4", 1, 1, 'h70, K1 ^ 32'h1);
      step("R4", 1, 1, 'h70, K1);
      step("R4", 1, 1, 'h14, 32'h7);
      // R4 wrong first key
      step("R4", 1, 1, 'h6C, K0 + 1);
      step("R4", 1, 1, 'h70, K1);
      step("R4", 1, 1, 'h20, 32'h8);
      // R5 byte writes to kicks
      step("R5", 1, 0, 'h6C, K0);
      step("R5", 1, 1, 'h70, K1);
      step("R5", 1, 1, 'h20, 32'h8);
      unlock_seq("R5");
      step("R5", 1, 0, 'h71, K1);
      step("R5", 1, 1, 'h20, 32'h8);
      // R9 arm survives unrelated writes
      step("R9", 1, 1, 'h6C, K0);
      step("R9", 1, 1, 'h54, 32'h9);
      step("R9", 1, 1, 'h08, 32'h9);
      step("R9", 1, 1, 'h70, K1);
      step("R9", 1, 1, 'h08, 32'h9);
      // R8 out-of-range, no-valid, byte-lane address
      step("R8", 1, 1, 'hA0, 32'hA);
      step("R8", 1, 1, 'hFC, 32'hA);
      step("R8", 0, 1, 'h08, 32'hA);
      step("R8", 1, 0, 'h0B, 32'hA);
      for (int i = 0; i < NREG; i++) step("R8", 1, 1, i * 4, 32'hB);
      // R1 reset while open
      @(negedge clk); rst_n = 1'b0; wr_valid = 1'b0;
      @(negedge clk); rst_n = 1'b1; mstate = 0;
      step("R1", 1, 1, 'h08, 32'hC);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule